// File: doc/BRIEF.md
# Tightly Coupled RAM Slave

This block sits between a processor's local memory port and a word-wide on-chip RAM. The processor starts a transfer by raising an address strobe together with either a read request or a write request. The block takes the address, byte-lane mask and write data in that cycle, then completes the access. It signals the finish with a one-cycle ready pulse. For reads, the stored word and two error flags appear in that same cycle.

The default build has zero wait states: ready follows the strobe by one clock. A build-time setting can stretch every transfer by one to three clocks. While the transfer is stretched, the block keeps its own copy of the request and raises a wait flag.

Every stored byte carries an even-parity bit. A per-lane injection input lets a test store a deliberately wrong parity bit, which exercises the two error flags.

Top module: `tcm_ram_slave`

## Requirements
- R1: While reset is held and right after it is released, `rdy`, `busy_wait`, `err_corr` and `err_uncorr` are 0 and `rdata` is zero.
- R2: With `WAIT_STATES` = 0, a strobe with a read or write request is answered by `rdy` = 1 in the very next cycle. `rdy` lasts exactly one cycle.
- R3: A read returns the word most recently written to the same word address.
- R4: On a write, `lane_en[i]` = 1 updates byte `wdata[8i+7:8i]`. Bytes whose lane bit is 0 keep their previous value.
- R5: The word address is `bus_addr[WORD_BITS+1:2]`, so the two low address bits do not select a different word. The address is taken only in the strobe cycle, and changes to `bus_addr` after that cycle do not redirect a pending transfer.
- R6: With `WAIT_STATES` = N > 0, `busy_wait` is 1 in the N cycles that follow the strobe. `rdy` is 1 in cycle N+1 after the strobe, and `busy_wait` is 0 in that ready cycle.
- R7: A strobe that arrives while `busy_wait` is 1 is ignored. It performs no write and produces no extra ready pulse.
- R8: `rdata` is zero in every cycle that is not the ready cycle of a read, including the ready cycle of a write.
- R9: Each byte is stored with an even-parity bit, and `par_inject[i]` inverts the stored bit of lane i on a write. In the ready cycle of a read, exactly one lane with a parity mismatch sets `err_corr` alone, and two or more such lanes set `err_uncorr` alone. Neither flag is ever 1 outside a read's ready cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address, sampled in the strobe cycle |
| bus_strobe | input | 1 | Address strobe |
| rd_req | input | 1 | Read request, given together with the strobe |
| wr_req | input | 1 | Write request, given together with the strobe |
| lane_en | input | 4 | Byte-lane write enables |
| wdata | input | 32 | Write data |
| par_inject | input | 4 | Per-lane parity inversion applied on write |
| rdata | output | 32 | Read data, nonzero only in a read's ready cycle |
| rdy | output | 1 | Transfer complete pulse |
| busy_wait | output | 1 | Accepted transfer still pending |
| err_corr | output | 1 | Single-lane parity mismatch on a read |
| err_uncorr | output | 1 | Multi-lane parity mismatch on a read |

## Verification
The bench runs two copies of the block, one with zero wait states and one with two.

**Stored data.** The zero-wait copy is first given full-word writes to distinct addresses. Reading those back tells a working store apart from one that mixes up addresses. Partial-lane writes over a known word then show whether each enable bit reaches its own byte and no other. An access through an address with nonzero low bits shows whether those bits are wrongly decoded.

**Parity.** Reads of words stored with zero, one and two inverted parity bits separate the three error outcomes from each other.

**Pending transfers.** On the wait-state copy, the bench changes the address and raises a second write strobe in the middle of a pending transfer. This checks that the captured address is the one used and that the stray strobe has no effect. It also checks the exact wait and ready timing.

// File: rtl/tcm_pkg.sv
package tcm_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;
  localparam int CELL_W = BYTE_W + 1;

  typedef logic [LANES-1:0]              lane_mask_t;
  typedef logic [LANES-1:0][CELL_W-1:0]  cell_word_t;
endpackage

// File: rtl/tcm_lane_ram.sv
module tcm_lane_ram #(
  parameter int WORD_BITS = 10,
  parameter int CELL_W    = 9
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 we,
  input  logic [WORD_BITS-1:0] idx,
  input  logic [CELL_W-1:0]    wcell,
  output logic [CELL_W-1:0]    rcell
);
  localparam int DEPTH = 1 << WORD_BITS;

  logic [CELL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[idx] <= wcell;
      rcell <= mem[idx];
    end
  end
endmodule

// File: rtl/tcm_xfer_ctrl.sv
module tcm_xfer_ctrl
  import tcm_pkg::*;
#(
  parameter int WORD_BITS   = 10,
  parameter int WAIT_STATES = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic                 rd_req,
  input  logic                 wr_req,
  input  logic [WORD_BITS-1:0] idx,
  input  lane_mask_t           be,
  input  logic [WORD_W-1:0]    wdata,
  input  lane_mask_t           inj,
  output logic                 fire,
  output logic                 f_rd,
  output lane_mask_t           f_be,
  output logic [WORD_BITS-1:0] f_idx,
  output logic [WORD_W-1:0]    f_wdata,
  output lane_mask_t           f_inj,
  output logic                 busy,
  output logic                 rdy,
  output logic                 rd_done
);
  logic take;
  assign take = strobe && (rd_req || wr_req) && !busy;

  generate
    if (WAIT_STATES == 0) begin : g_direct
      assign busy    = 1'b0;
      assign fire    = take;
      assign f_rd    = rd_req && !wr_req;
      assign f_be    = wr_req ? be : '0;
      assign f_idx   = idx;
      assign f_wdata = wdata;
      assign f_inj   = inj;
    end else begin : g_held
      localparam int CNT_W = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
      localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(WAIT_STATES - 1);

      logic                 pend_q;
      logic [CNT_W-1:0]     cnt_q;
      logic                 rd_q;
      lane_mask_t           be_q, inj_q;
      logic [WORD_BITS-1:0] idx_q;
      logic [WORD_W-1:0]    wd_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else if (take) begin
          pend_q <= 1'b1;
          cnt_q  <= CNT_INIT;
        end else if (pend_q) begin
          if (cnt_q == '0) pend_q <= 1'b0;
          else             cnt_q  <= cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk) begin
        if (take) begin
          rd_q  <= rd_req && !wr_req;
          be_q  <= wr_req ? be : '0;
          idx_q <= idx;
          wd_q  <= wdata;
          inj_q <= inj;
        end
      end

      assign busy    = pend_q;
      assign fire    = pend_q && (cnt_q == '0);
      assign f_rd    = rd_q;
      assign f_be    = be_q;
      assign f_idx   = idx_q;
      assign f_wdata = wd_q;
      assign f_inj   = inj_q;

      assert_hold_captured_R5: assert property (@(posedge clk) disable iff (rst)
        (pend_q && cnt_q != '0) |=> (pend_q && $stable(idx_q) && $stable(be_q)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy     <= 1'b0;
      rd_done <= 1'b0;
    end else begin
      rdy     <= fire;
      rd_done <= fire && f_rd;
    end
  end

  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy || busy == 1'b0);
  assert_wait_clear_at_ready_R6: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !busy);
  assert_wait_ends_in_ready_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rdy);
endmodule

// File: rtl/tcm_parity_chk.sv
module tcm_parity_chk
  import tcm_pkg::*;
(
  input  cell_word_t          cells,
  output logic [WORD_W-1:0]   data,
  output logic [2:0]          bad_lanes
);
  lane_mask_t mism;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign data[i*BYTE_W +: BYTE_W] = cells[i][BYTE_W-1:0];
      assign mism[i] = ^cells[i];
    end
  endgenerate

  assign bad_lanes = 3'($countones(mism));
endmodule

// File: rtl/tcm_ram_slave.sv
module tcm_ram_slave
  import tcm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_BITS   = 10,
  parameter int WAIT_STATES = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_strobe,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [3:0]        lane_en,
  input  logic [31:0]       wdata,
  input  logic [3:0]        par_inject,
  output logic [31:0]       rdata,
  output logic              rdy,
  output logic              busy_wait,
  output logic              err_corr,
  output logic              err_uncorr
);
  logic                 fire, f_rd, rd_done;
  lane_mask_t           f_be, f_inj;
  logic [WORD_BITS-1:0] f_idx;
  logic [WORD_W-1:0]    f_wdata, rd_word;
  cell_word_t           rcells;
  logic [2:0]           bad_lanes;
  logic                 addr_unused;

  assign addr_unused = ^{bus_addr[ADDR_W-1:WORD_BITS+2], bus_addr[1:0]};

  tcm_xfer_ctrl #(.WORD_BITS(WORD_BITS), .WAIT_STATES(WAIT_STATES)) u_ctrl (
    .clk(clk), .rst(rst), .strobe(bus_strobe), .rd_req(rd_req), .wr_req(wr_req),
    .idx(bus_addr[WORD_BITS+1:2]), .be(lane_en), .wdata(wdata), .inj(par_inject),
    .fire(fire), .f_rd(f_rd), .f_be(f_be), .f_idx(f_idx), .f_wdata(f_wdata),
    .f_inj(f_inj), .busy(busy_wait), .rdy(rdy), .rd_done(rd_done));

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_ram
      logic [BYTE_W-1:0] wbyte;
      assign wbyte = f_wdata[i*BYTE_W +: BYTE_W];
      tcm_lane_ram #(.WORD_BITS(WORD_BITS), .CELL_W(CELL_W)) u_lane (
        .clk(clk), .en(fire), .we(f_be[i]), .idx(f_idx),
        .wcell({^wbyte ^ f_inj[i], wbyte}), .rcell(rcells[i]));
    end
  endgenerate

  tcm_parity_chk u_chk (.cells(rcells), .data(rd_word), .bad_lanes(bad_lanes));

  assign rdata      = rd_done ? rd_word : '0;
  assign err_corr   = rd_done && (bad_lanes == 3'd1);
  assign err_uncorr = rd_done && (bad_lanes >= 3'd2);

  assert_quiet_data_R8: assert property (@(posedge clk) disable iff (rst)
    !rdy |-> (rdata == '0));
  assert_flags_with_ready_R9: assert property (@(posedge clk) disable iff (rst)
    (err_corr || err_uncorr) |-> rdy);
  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(err_corr && err_uncorr));
  assert_accept_response_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_strobe && (rd_req || wr_req) && !busy_wait) |=>
      ((WAIT_STATES == 0) ? rdy : (busy_wait && !rdy)));
endmodule

// File: tb/tcm_ram_slave_bench.sv
module tcm_ram_slave_bench;
  logic clk = 1'b0;
  logic rst;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [31:0] a_addr, a_wd, a_rdata;
  logic        a_stb, a_rd, a_wr, a_rdy, a_wait, a_ce, a_ue;
  logic [3:0]  a_be, a_inj;

  logic [31:0] b_addr, b_wd, b_rdata;
  logic        b_stb, b_rd, b_wr, b_rdy, b_wait, b_ce, b_ue;
  logic [3:0]  b_be, b_inj;

  tcm_ram_slave #(.WAIT_STATES(0)) u_tcm_ram_slave (
    .clk(clk), .rst(rst), .bus_addr(a_addr), .bus_strobe(a_stb), .rd_req(a_rd),
    .wr_req(a_wr), .lane_en(a_be), .wdata(a_wd), .par_inject(a_inj),
    .rdata(a_rdata), .rdy(a_rdy), .busy_wait(a_wait), .err_corr(a_ce), .err_uncorr(a_ue));

  tcm_ram_slave #(.WAIT_STATES(2)) u_tcm_ram_slave_ws (
    .clk(clk), .rst(rst), .bus_addr(b_addr), .bus_strobe(b_stb), .rd_req(b_rd),
    .wr_req(b_wr), .lane_en(b_be), .wdata(b_wd), .par_inject(b_inj),
    .rdata(b_rdata), .rdy(b_rdy), .busy_wait(b_wait), .err_corr(b_ce), .err_uncorr(b_ue));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic a_xfer(input logic [31:0] addr, input logic wr, input logic [3:0] be,
                        input logic [31:0] d, input logic [3:0] inj,
                        output logic [31:0] rd, output logic r, output logic ce, output logic ue);
    @(negedge clk);
    a_addr = addr; a_stb = 1'b1; a_rd = !wr; a_wr = wr; a_be = be; a_wd = d; a_inj = inj;
    @(negedge clk);
    a_stb = 1'b0; a_rd = 1'b0; a_wr = 1'b0; a_addr = 32'hFFFF_FFFF;
    rd = a_rdata; r = a_rdy; ce = a_ce; ue = a_ue;
  endtask

  task automatic b_xfer(input logic [31:0] addr, input logic wr, input logic [31:0] d,
                        input logic disturb, output logic [31:0] rd,
                        output logic ce, output logic ue);
    @(negedge clk);
    b_addr = addr; b_stb = 1'b1; b_rd = !wr; b_wr = wr; b_be = 4'hF; b_wd = d; b_inj = 4'h0;
    @(negedge clk);
    b_stb = 1'b0; b_rd = 1'b0; b_wr = 1'b0;
    chk("R6 wait in cycle 1", {b_wait, b_rdy}, 32'h2);
    if (disturb) begin
      b_addr = 32'h0000_0200; b_stb = 1'b1; b_wr = 1'b1; b_wd = 32'hBAD0_BAD0;
    end else b_addr = 32'h0000_0300;
    @(negedge clk);
    b_stb = 1'b0; b_wr = 1'b0;
    chk("R6 wait in cycle 2", {b_wait, b_rdy}, 32'h2);
    @(negedge clk);
    chk("R6 ready in cycle 3", {b_wait, b_rdy}, 32'h1);
    rd = b_rdata; ce = b_ce; ue = b_ue;
    @(negedge clk);
    chk("R7 no extra ready", {b_wait, b_rdy}, 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 reset outputs a", {a_rdy, a_wait, a_ce, a_ue}, 32'h0);
    chk("R1 reset rdata a", a_rdata, 32'h0);
    chk("R1 reset outputs b", {b_rdy, b_wait, b_ce, b_ue}, 32'h0);
  endtask

  task automatic t_basic;
    logic [31:0] rd; logic r, ce, ue;
    a_xfer(32'h40, 1'b1, 4'hF, 32'h1234_5678, 4'h0, rd, r, ce, ue);
    chk("R2 write ready next cycle", r, 1);
    chk("R8 rdata zero on write ready", rd, 0);
    @(negedge clk);
    chk("R2 ready single cycle", a_rdy, 0);
    chk("R8 rdata zero when idle", a_rdata, 0);
    a_xfer(32'h44, 1'b1, 4'hF, 32'hCAFE_F00D, 4'h0, rd, r, ce, ue);
    a_xfer(32'h80, 1'b1, 4'hF, 32'h0000_0001, 4'h0, rd, r, ce, ue);
    a_xfer(32'h40, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R2 read ready next cycle", r, 1);
    chk("R3 readback 0x40", rd, 32'h1234_5678);
    chk("R9 clean read flags", {ce, ue}, 0);
    a_xfer(32'h44, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R3 readback 0x44", rd, 32'hCAFE_F00D);
    a_xfer(32'h80, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R3 readback 0x80", rd, 32'h0000_0001);
    a_xfer(32'h43, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R5 low address bits ignored", rd, 32'h1234_5678);
  endtask

  task automatic t_lanes;
    logic [31:0] rd; logic r, ce, ue;
    a_xfer(32'h40, 1'b1, 4'b0101, 32'hAABB_CCDD, 4'h0, rd, r, ce, ue);
    a_xfer(32'h40, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R4 lanes 0 and 2", rd, 32'h12BB_56DD);
    a_xfer(32'h40, 1'b1, 4'b1000, 32'h9900_0000, 4'h0, rd, r, ce, ue);
    a_xfer(32'h40, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R4 lane 3 only", rd, 32'h99BB_56DD);
    chk("R9 partial writes keep parity", {ce, ue}, 0);
  endtask

  task automatic t_parity;
    logic [31:0] rd; logic r, ce, ue;
    a_xfer(32'h100, 1'b1, 4'hF, 32'h0F0F_0F0F, 4'b0010, rd, r, ce, ue);
    chk("R9 no flags on write", {ce, ue}, 0);
    a_xfer(32'h100, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R9 one bad lane data", rd, 32'h0F0F_0F0F);
    chk("R9 one bad lane flags", {ce, ue}, 32'h2);
    a_xfer(32'h104, 1'b1, 4'hF, 32'h8001_7F00, 4'b1001, rd, r, ce, ue);
    a_xfer(32'h104, 1'b0, 4'h0, 0, 4'h0, rd, r, ce, ue);
    chk("R9 two bad lanes flags", {ce, ue}, 32'h1);
    @(negedge clk);
    chk("R9 flags drop after ready", {a_ce, a_ue}, 0);
  endtask

  task automatic t_wait_states;
    logic [31:0] rd; logic ce, ue;
    b_xfer(32'h200, 1'b1, 32'h5555_AAAA, 1'b0, rd, ce, ue);
    chk("R8 write ready rdata zero", rd, 0);
    b_xfer(32'h20, 1'b1, 32'h0BAD_CAFE, 1'b1, rd, ce, ue);
    b_xfer(32'h20, 1'b0, 0, 1'b0, rd, ce, ue);
    chk("R5 captured address used", rd, 32'h0BAD_CAFE);
    chk("R9 clean flags wait mode", {ce, ue}, 0);
    b_xfer(32'h200, 1'b0, 0, 1'b0, rd, ce, ue);
    chk("R7 ignored strobe wrote nothing", rd, 32'h5555_AAAA);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    a_addr = 0; a_stb = 0; a_rd = 0; a_wr = 0; a_be = 0; a_wd = 0; a_inj = 0;
    b_addr = 0; b_stb = 0; b_rd = 0; b_wr = 0; b_be = 0; b_wd = 0; b_inj = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_lanes();
    t_parity();
    t_wait_states();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule